// File: doc/BRIEF.md
# SDRAM Precharge-to-Activate Delay Timer

This block guards the gap between closing a row and opening the next one in a synchronous DRAM controller. The command sequencer pulses one of four event inputs when it issues a command: an ordinary precharge, an all-bank precharge that is part of an auto-refresh, a single-bank precharge while running in bank-active mode, or the exit from self-refresh. The timer looks up the minimum wait for that kind of event under the current 2-bit delay setting, counts it down, and raises `act_ok` once another bank-activate may be sent.

The setting lives in a 16-bit configuration register, in bits [15:14]. Only the power-on reset clears this register. The manual reset leaves the register and the initialisation flag alone and stops any running count. Until software has written the register once after power-on, `act_ok` stays low, which holds off any access to the memory. Setting 01 is illegal in bank-active mode, and the block flags that combination.

Top module: `sdram_trp_timer`

## Requirements
- R1: While `por_n` is low and after it is released, `cfg_rdata` reads 0, `init_done` is 0 and `act_ok` is 0.
- R2: A cycle with `cfg_we` high stores all 16 bits of `cfg_wdata`, and `cfg_rdata` shows them from the next cycle. The delay setting `s` is bits [15:14]. Without a write the register keeps its value.
- R3: A cycle with `mrst_n` low clears the running wait, so `act_ok` is high in the next cycle if `init_done` is set. It does not change the register or `init_done`.
- R4: `init_done` is set by the first write after power-on and stays set until the next power-on reset. `act_ok` is 0 while `init_done` is 0.
- R5: After an `ev_pre` pulse, `act_ok` is low for exactly s+1 cycles and then returns high.
- R6: After an `ev_pall_ref` or `ev_pre_bam` pulse, `act_ok` is low for exactly s cycles. When s=0, `act_ok` does not drop and no count is loaded.
- R7: After an `ev_srx` pulse, `act_ok` is low for exactly 3·s+2 cycles (2, 5, 8 or 11).
- R8: An event that arrives while a wait is running restarts the wait with the length for the new event, measured from that event.
- R9: When several events pulse in the same cycle, the wait is taken from the highest-priority one: `ev_srx` first, then `ev_pre`, then the shortened kinds.
- R10: `cfg_err` is high exactly when `bank_active` is high and s equals 01.
- R11: An event in the same cycle as a register write uses the setting held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low; clears only the wait counter |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration register write data |
| cfg_rdata | output | 16 | Configuration register contents |
| bank_active | input | 1 | Controller is in bank-active mode |
| ev_pre | input | 1 | Pulse: normal precharge issued |
| ev_pall_ref | input | 1 | Pulse: all-bank precharge issued for auto-refresh |
| ev_pre_bam | input | 1 | Pulse: precharge issued in bank-active mode |
| ev_srx | input | 1 | Pulse: self-refresh exit |
| act_ok | output | 1 | A bank-activate may be issued |
| init_done | output | 1 | Register written since power-on |
| cfg_err | output | 1 | Setting 01 selected while in bank-active mode |

## Verification
The bench builds the block with its default parameters: a 16-bit register, a 2-bit setting at bit 14, and a derived 4-bit counter. With these values every one of the four settings can be reached, including the longest wait of 11 cycles after self-refresh exit. Random event streams land restarts at every counter value and produce simultaneous pulses that exercise the priority order. Directed steps cover the zero-cycle shortened wait, events before initialisation, a write in the same cycle as an event, and manual reset in the middle of a count.

// File: rtl/sdram_trp_pkg.sv
package sdram_trp_pkg;

    // Kind of command that starts a precharge-to-activate wait
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_SHORT  = 2'd1,   // all-bank precharge for refresh, or bank-active precharge
        EV_NORMAL = 2'd2,   // ordinary precharge
        EV_SREXIT = 2'd3    // self-refresh exit
    } trp_ev_e;

    // Wait length in cycles for an event kind under setting s
    function automatic int unsigned trp_wait(trp_ev_e kind, int unsigned s);
        case (kind)
            EV_SHORT:  return s;
            EV_NORMAL: return s + 1;
            EV_SREXIT: return 3 * s + 2;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/sdram_trp_cfg.sv
module sdram_trp_cfg #(
    parameter int REG_W     = 16,
    parameter int SET_W     = 2,
    parameter int FIELD_LSB = 14
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [SET_W-1:0] setting,
    output logic             init_done
);

    typedef struct packed {
        logic [REG_W-1:0] val;
        logic             init;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val  = wdata;
            st_d.init = 1'b1;
        end
    end

    // Only the power-on reset clears the register and the init flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.val;
    assign setting   = st_q.val[FIELD_LSB +: SET_W];
    assign init_done = st_q.init;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !we |=> $stable(rdata));                                    // R2
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        init_done |=> init_done);                                   // R4
    AST_INIT_BY_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(init_done) |-> $past(we));                            // R4

endmodule

// File: rtl/sdram_trp_sel.sv
module sdram_trp_sel
    import sdram_trp_pkg::*;
#(
    parameter int SET_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             ev_pre,
    input  logic             ev_pall_ref,
    input  logic             ev_pre_bam,
    input  logic             ev_srx,
    input  logic [SET_W-1:0] setting,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    trp_ev_e kind;

    // Priority: self-refresh exit, then normal precharge, then shortened kinds
    always_comb begin
        if (ev_srx)                         kind = EV_SREXIT;
        else if (ev_pre)                    kind = EV_NORMAL;
        else if (ev_pall_ref || ev_pre_bam) kind = EV_SHORT;
        else                                kind = EV_NONE;
    end

    assign load     = (kind != EV_NONE);
    assign load_val = CNT_W'(trp_wait(kind, 32'(setting)));

endmodule

// File: rtl/sdram_trp_cnt.sv
module sdram_trp_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n)
            st_d.cnt = '0;
        else if (load)
            st_d.cnt = load_val;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle = (st_q.cnt == '0);

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (!load && !idle) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R5
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        load |=> (st_q.cnt == $past(load_val)));                    // R8

endmodule

// File: rtl/sdram_trp_timer.sv
module sdram_trp_timer
    import sdram_trp_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int SET_W     = 2,
    parameter int FIELD_LSB = 14
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             bank_active,
    input  logic             ev_pre,
    input  logic             ev_pall_ref,
    input  logic             ev_pre_bam,
    input  logic             ev_srx,
    output logic             act_ok,
    output logic             init_done,
    output logic             cfg_err
);

    localparam int MAX_WAIT = 3 * ((1 << SET_W) - 1) + 2;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic [SET_W-1:0] setting;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             idle;

    sdram_trp_cfg #(.REG_W(REG_W), .SET_W(SET_W), .FIELD_LSB(FIELD_LSB)) u_cfg (
        .clk       (clk),
        .por_n     (por_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .setting   (setting),
        .init_done (init_done)
    );

    sdram_trp_sel #(.SET_W(SET_W), .CNT_W(CNT_W)) u_sel (
        .ev_pre      (ev_pre),
        .ev_pall_ref (ev_pall_ref),
        .ev_pre_bam  (ev_pre_bam),
        .ev_srx      (ev_srx),
        .setting     (setting),
        .load        (load),
        .load_val    (load_val)
    );

    sdram_trp_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .mrst_n   (mrst_n),
        .load     (load),
        .load_val (load_val),
        .idle     (idle)
    );

    assign act_ok  = init_done && idle;
    assign cfg_err = bank_active && (setting == SET_W'(1));

    AST_SREXIT_BLOCKS: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        ev_srx |=> !act_ok);                                        // R7
    AST_NORMAL_BLOCKS: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        ev_pre |=> !act_ok);                                        // R5

endmodule

// File: tb/sdram_trp_timer_test.sv
module sdram_trp_timer_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        bank_active = 1'b0;
    logic        ev_pre = 1'b0, ev_pall_ref = 1'b0, ev_pre_bam = 1'b0, ev_srx = 1'b0;
    logic        act_ok, init_done, cfg_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [15:0] m_cfg = '0;
    bit          m_init = 1'b0;
    int          m_cnt = 0;
    string       tag = "R1";

    always #5 clk = ~clk;

    sdram_trp_timer uut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bank_active(bank_active),
        .ev_pre(ev_pre), .ev_pall_ref(ev_pall_ref), .ev_pre_bam(ev_pre_bam), .ev_srx(ev_srx),
        .act_ok(act_ok), .init_done(init_done), .cfg_err(cfg_err)
    );

    function automatic int exp_wait(bit srx, bit pre, bit shrt, int s);
        if (srx)  return 3 * s + 2;
        if (pre)  return s + 1;
        if (shrt) return s;
        return 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check(tag, "act_ok", int'(act_ok), int'(m_init && m_cnt == 0));
        check("R4", "init_done", int'(init_done), int'(m_init));
        check("R2", "cfg_rdata", int'(cfg_rdata), int'(m_cfg));
        check("R10", "cfg_err", int'(cfg_err), int'(bank_active && m_cfg[15:14] == 2'b01));
    endtask

    // Advance one clock: model takes the inputs present now, then outputs are checked
    task automatic tick();
        int  s = int'(m_cfg[15:14]);
        bit  shrt = ev_pall_ref || ev_pre_bam;
        bit  any = ev_srx || ev_pre || shrt;
        if (por_n) begin
            if (!mrst_n) begin
                m_cnt = 0; tag = "R3";
            end else if (any) begin
                m_cnt = exp_wait(ev_srx, ev_pre, shrt, s);          // R11: old setting
                tag = ev_srx ? "R7" : ev_pre ? "R5" : "R6";
                if (ev_srx && (ev_pre || shrt)) tag = "R9";
                else if (m_cnt != 0 && cfg_we) tag = "R11";
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            if (cfg_we) begin
                m_cfg = cfg_wdata; m_init = 1'b1;
            end
        end
        @(negedge clk);
        check_outputs();
        ev_pre = 0; ev_pall_ref = 0; ev_pre_bam = 0; ev_srx = 0;
        cfg_we = 0; mrst_n = 1;
    endtask

    task automatic write_cfg(logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4021));
        // R1: reset state while held and after release
        repeat (3) @(negedge clk);
        tag = "R1";
        check_outputs();
        por_n = 1'b1;
        tick();
        // R4: events before initialisation keep act_ok low
        tag = "R4";
        ev_pre = 1; tick();
        idle_cycles(4);
        // R2/R4: first write
        write_cfg(16'h0000);
        idle_cycles(2);
        // R5/R6/R7 directed over every setting
        for (int s = 0; s < 4; s++) begin
            write_cfg({s[1:0], 14'h1a5});
            ev_pre = 1; tick(); idle_cycles(s + 2);
            ev_pall_ref = 1; tick(); idle_cycles(s + 2);
            ev_pre_bam = 1; tick(); idle_cycles(s + 2);
            ev_srx = 1; tick(); idle_cycles(3 * s + 3);
        end
        // R8: reload mid-count, srx then short
        write_cfg(16'hC000);
        ev_srx = 1; tick(); idle_cycles(4);
        ev_pre_bam = 1; tick(); idle_cycles(5);
        // R9: simultaneous pulses
        ev_srx = 1; ev_pre = 1; ev_pall_ref = 1; tick(); idle_cycles(12);
        ev_pre = 1; ev_pre_bam = 1; tick(); idle_cycles(6);
        // R11: event in same cycle as write
        ev_srx = 1; cfg_we = 1; cfg_wdata = 16'h0000; tick(); idle_cycles(12);
        // R3: manual reset mid-count keeps cfg and init
        write_cfg(16'hC0F0);
        ev_srx = 1; tick(); tick();
        mrst_n = 0; tick(); idle_cycles(2);
        // R10: illegal setting in bank-active mode
        write_cfg(16'h4000);
        bank_active = 1; tick(); bank_active = 0; tick();
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bank_active = ($urandom % 2) == 0;
            ev_pre      = ($urandom % 9) == 0;
            ev_pall_ref = ($urandom % 9) == 0;
            ev_pre_bam  = ($urandom % 9) == 0;
            ev_srx      = ($urandom % 14) == 0;
            cfg_we      = ($urandom % 60) == 0;
            cfg_wdata   = 16'($urandom);
            mrst_n      = ($urandom % 50) != 0;
            tick();
        end
        finished = 1'b1;
        finish_run();
    end

endmodule